// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block watches the first byte that follows a START (or repeated START) on an I2C bus and decides whether this device is the target. It shifts in SDA most significant bit first on each SCL rising edge. After eight bits it treats the upper seven as the target address and the lowest bit as the transfer direction. It compares the address with a programmable own address and, if enabled, with the all-zeros general-call address. A successful match raises a one-cycle strobe for the control logic and records which kind of match occurred. The block then pulls SDA low through the ninth clock to acknowledge.

The block works on pre-processed bus events. SCL edges and START/STOP conditions arrive as single-cycle strobes from a front end that has already filtered and synchronised the lines. The own-address configuration byte and a software acknowledge-enable bit come from the register file. The transfer of data bytes after the address belongs to other logic.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `match_pulse`, `sda_pull` and `rw_bit` are 0 and `match_kind` is 2'b00 (no match).
- R2: When the received address equals `own_cfg[7:1]` and `ack_en` is 1, `match_pulse` is high for exactly one clock cycle and `match_kind` becomes 2'b01. A configuration of 8'hFE (the register's reset value) makes address 7'h7F the own address.
- R3: On a match, `rw_bit` takes bit 0 of the received byte (1 = read, 0 = write). It holds that value until the next START or STOP.
- R4: A received address of 7'h00 gives a general-call match (`match_kind` = 2'b10, one `match_pulse`, acknowledge) only when `own_cfg[0]` is 1. With `own_cfg[0]` = 0, the same address produces no strobe and no acknowledge.
- R5: An address that matches neither target produces no strobe, leaves `match_kind` at 2'b00 and never asserts `sda_pull`.
- R6: While `ack_en` is 0, a matching address is ignored: no strobe, no acknowledge, and `match_kind` stays 2'b00. After `ack_en` returns to 1, the next addressed transfer matches normally.
- R7: On a match, `sda_pull` rises on the first SCL falling edge after the eighth rising edge. It stays high through the ninth rising edge and drops on the SCL falling edge that follows.
- R8: A START or repeated START at any point restarts the bit count, so bits received before it do not enter the address comparison.
- R9: A STOP returns the block to idle: `sda_pull`, `rw_bit` and `match_kind` go to 0. SCL edges that follow without a new START produce no match.
- R10: Bits are taken most significant first. A byte carrying the bit-reversed own address does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| sda_in | input | 1 | Filtered SDA level |
| start_det | input | 1 | One-cycle strobe on START or repeated START |
| stop_det | input | 1 | One-cycle strobe on STOP |
| own_cfg | input | 8 | Own address in bits 7..1, general-call enable in bit 0 |
| ack_en | input | 1 | Software acknowledge enable |
| match_pulse | output | 1 | One-cycle strobe when the device is addressed |
| match_kind | output | 2 | 00 none, 01 own address, 10 general call |
| rw_bit | output | 1 | Direction bit of the matched byte (1 = read) |
| sda_pull | output | 1 | Request to drive SDA low (acknowledge) |

## Verification
The hardest case to reach from the ports is a repeated START in the middle of an address byte. The bits already shifted must be thrown away and must not leak into the next comparison. The bench reaches it by sending four bits, raising the START strobe, and then sending a full matching byte. It then checks for exactly one strobe and the correct direction bit. A second hard case is the acknowledge window. The bench steps the eighth and ninth clocks edge by edge and samples `sda_pull` between each pair of strobes.

// File: rtl/i2c_am_pkg.sv
// Shared types for the I2C slave address match unit.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package i2c_am_pkg;

    typedef enum logic [1:0] {
        MK_NONE  = 2'b00,
        MK_OWN   = 2'b01,
        MK_GCALL = 2'b10
    } match_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SETUP,
        ST_ACK_LOW,
        ST_ACK_HIGH,
        ST_HOLD
    } am_state_e;

endpackage

// File: rtl/i2c_am_shift.sv
// Address byte shifter: collects BITS bits of SDA, MSB first, on SCL rising
// edges while enabled, and strobes byte_done the cycle after the last bit.
// Assumes: scl_rise is a one-cycle strobe; clear has priority over shifting.
module i2c_am_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            scl_rise,
    input  logic            sda_in,
    output logic [BITS-1:0] byte_q,
    output logic            byte_done
);
    localparam int CW = $clog2(BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0] cnt;

    // Shift SDA in and count bits; restart the count on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (shift_en && scl_rise) begin
                byte_q <= {byte_q[BITS-2:0], sda_in};
                if (cnt == LAST) begin
                    cnt       <= '0;
                    byte_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_am_compare.sv
// Address comparator: classifies a received byte as own-address match,
// general-call match or no match. A match counts only when ack_en is set.
// Own-address match wins over general call if both hold.
// Assumes: rx_byte bit 0 is the direction bit and is not compared.
module i2c_am_compare
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter bit GCALL_EN = 1'b1
) (
    input  logic [ADDR_W:0] rx_byte,
    input  logic [ADDR_W:0] own_cfg,
    input  logic            ack_en,
    output match_kind_e     kind
);
    logic own_hit;
    logic gc_hit;

    assign own_hit = (rx_byte[ADDR_W:1] == own_cfg[ADDR_W:1]);

    generate
        if (GCALL_EN) begin : g_gcall
            assign gc_hit = (rx_byte[ADDR_W:1] == '0) && own_cfg[0];
        end else begin : g_no_gcall
            assign gc_hit = 1'b0;
        end
    endgenerate

    // Pick the match class, gated by the acknowledge enable.
    always_comb begin
        kind = MK_NONE;
        if (ack_en) begin
            if (own_hit)     kind = MK_OWN;
            else if (gc_hit) kind = MK_GCALL;
        end
    end
endmodule

// File: rtl/i2c_am_ctl.sv
// Transfer sequencer: follows START/STOP, enables the shifter during the
// address byte, latches match kind and direction, and drives the
// acknowledge window over the ninth SCL clock.
// Assumes: strobes are one cycle wide and SCL edges are at least two clock
// cycles apart; STOP has priority over START.
module i2c_am_ctl
    import i2c_am_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_det,
    input  logic        stop_det,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        byte_done,
    input  logic        rx_rw,
    input  match_kind_e cmp_kind,
    output logic        shift_en,
    output logic        match_pulse,
    output match_kind_e match_kind,
    output logic        rw_bit,
    output logic        sda_pull
);
    am_state_e state;

    assign shift_en = (state == ST_ADDR);

    // Sequence one addressed transfer and the acknowledge window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            match_pulse <= 1'b0;
            match_kind  <= MK_NONE;
            rw_bit      <= 1'b0;
            sda_pull    <= 1'b0;
        end else begin
            match_pulse <= 1'b0;
            if (stop_det) begin
                state      <= ST_IDLE;
                match_kind <= MK_NONE;
                rw_bit     <= 1'b0;
                sda_pull   <= 1'b0;
            end else if (start_det) begin
                state      <= ST_ADDR;
                match_kind <= MK_NONE;
                rw_bit     <= 1'b0;
                sda_pull   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (byte_done) begin
                            if (cmp_kind != MK_NONE) begin
                                match_kind  <= cmp_kind;
                                rw_bit      <= rx_rw;
                                match_pulse <= 1'b1;
                                state       <= ST_ACK_SETUP;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_ACK_SETUP: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK_LOW;
                        end
                    end
                    ST_ACK_LOW: begin
                        if (scl_rise) state <= ST_ACK_HIGH;
                    end
                    ST_ACK_HIGH: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
// I2C slave address match unit (top). Shifts in the first byte after a
// START, compares it with the own address and general call, reports the
// match and requests SDA low for the acknowledge bit.
// Assumes: filtered, synchronised bus event strobes from a front end.
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter bit GCALL_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_in,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [ADDR_W:0] own_cfg,
    input  logic            ack_en,
    output logic            match_pulse,
    output logic [1:0]      match_kind,
    output logic            rw_bit,
    output logic            sda_pull
);
    localparam int BYTE_W = ADDR_W + 1;

    logic              shift_en;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    match_kind_e       cmp_kind;
    match_kind_e       kind_q;

    i2c_am_shift #(.BITS(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_det | stop_det),
        .shift_en  (shift_en),
        .scl_rise  (scl_rise),
        .sda_in    (sda_in),
        .byte_q    (rx_byte),
        .byte_done (byte_done)
    );

    i2c_am_compare #(.ADDR_W(ADDR_W), .GCALL_EN(GCALL_EN)) u_cmp (
        .rx_byte (rx_byte),
        .own_cfg (own_cfg),
        .ack_en  (ack_en),
        .kind    (cmp_kind)
    );

    i2c_am_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .byte_done   (byte_done),
        .rx_rw       (rx_byte[0]),
        .cmp_kind    (cmp_kind),
        .shift_en    (shift_en),
        .match_pulse (match_pulse),
        .match_kind  (kind_q),
        .rw_bit      (rw_bit),
        .sda_pull    (sda_pull)
    );

    assign match_kind = kind_q;
endmodule

// File: rtl/i2c_am_checker.sv
// Property checker for i2c_addr_match, bound to every instance of the top.
// Assumes: same port meanings as the top; checks are off during reset.
module i2c_am_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_rise,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       ack_en,
    input logic       match_pulse,
    input logic [1:0] match_kind,
    input logic       rw_bit,
    input logic       sda_pull
);
    // Strobe lasts a single cycle.
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    // A strobe always comes with a reported match class, never both classes.
    p_pulse_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (match_kind == 2'b01 || match_kind == 2'b10));

    p_kind_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_kind));

    // A match needs the acknowledge enable in the comparison cycle.
    p_need_ack_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(ack_en));

    // Acknowledge starts only on an SCL falling edge after a match.
    p_pull_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> ($past(scl_fall) && match_kind != 2'b00));

    // Acknowledge ends only on an SCL falling edge or a bus condition.
    p_pull_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

    // Direction changes only with a match or a bus condition.
    p_rw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rw_bit) |-> (match_pulse || $past(start_det) || $past(stop_det)));

    // STOP returns to idle.
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (match_kind == 2'b00 && !sda_pull && !rw_bit));
endmodule

bind i2c_addr_match i2c_am_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .ack_en      (ack_en),
    .match_pulse (match_pulse),
    .match_kind  (match_kind),
    .rw_bit      (rw_bit),
    .sda_pull    (sda_pull)
);

// File: tb/i2c_addr_match_tb_top.sv
`timescale 1ns/100ps
module i2c_addr_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b1;
    logic       start_det = 1'b0, stop_det = 1'b0;
    logic [7:0] own_cfg = 8'hFE;
    logic       ack_en = 1'b1;
    logic       match_pulse;
    logic [1:0] match_kind;
    logic       rw_bit, sda_pull;

    int vectors = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_addr_match dut_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
        .own_cfg(own_cfg), .ack_en(ack_en), .match_pulse(match_pulse),
        .match_kind(match_kind), .rw_bit(rw_bit), .sda_pull(sda_pull)
    );

    always @(posedge clk) if (rst_n && match_pulse) pulses <= pulses + 1;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
        idle(2);
    endtask

    task automatic strobe_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
        idle(2);
    endtask

    task automatic rise();
        @(negedge clk) scl_rise = 1'b1;
        @(negedge clk) scl_rise = 1'b0;
        idle(3);
    endtask

    task automatic fall();
        @(negedge clk) scl_fall = 1'b1;
        @(negedge clk) scl_fall = 1'b0;
        idle(3);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sda_in = b;
        idle(1);
        rise();
        fall();
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic ack_clock();
        rise();
        fall();
    endtask

    task automatic t_reset();
        chk("R1 pulse", match_pulse, 0);
        chk("R1 kind", match_kind, 0);
        chk("R1 rw", rw_bit, 0);
        chk("R1 pull", sda_pull, 0);
    endtask

    // Own-address read with edge-by-edge acknowledge window.
    task automatic t_own_read();
        int p0;
        own_cfg = 8'hA4;
        ack_en = 1'b1;
        strobe_start();
        p0 = pulses;
        for (int i = 7; i >= 1; i--) send_bit(logic'(8'hA5 >> i));
        @(negedge clk) sda_in = 1'b1;
        idle(1);
        rise();
        chk("R2 one strobe", pulses - p0, 1);
        chk("R2 kind own", match_kind, 1);
        chk("R3 rw read", rw_bit, 1);
        chk("R7 no pull before fall", sda_pull, 0);
        fall();
        chk("R7 pull after 8th fall", sda_pull, 1);
        rise();
        chk("R7 pull over 9th rise", sda_pull, 1);
        fall();
        chk("R7 release after 9th fall", sda_pull, 0);
        send_byte(8'h3C);
        chk("R3 rw held", rw_bit, 1);
        chk("R2 no extra strobe", pulses - p0, 1);
        strobe_stop();
        chk("R9 kind idle", match_kind, 0);
        chk("R9 rw cleared", rw_bit, 0);
    endtask

    // Reset-value configuration: address 7F, no general call.
    task automatic t_default_cfg();
        int p0;
        own_cfg = 8'hFE;
        strobe_start();
        p0 = pulses;
        send_byte(8'hFE);
        chk("R2 default addr strobe", pulses - p0, 1);
        chk("R3 rw write", rw_bit, 0);
        chk("R2 pull on default", sda_pull, 1);
        ack_clock();
        strobe_start();
        p0 = pulses;
        send_byte(8'h00);
        chk("R4 gcall disabled strobe", pulses - p0, 0);
        chk("R4 gcall disabled pull", sda_pull, 0);
        chk("R4 gcall disabled kind", match_kind, 0);
        strobe_stop();
    endtask

    task automatic t_gcall();
        int p0;
        own_cfg = 8'h31;
        strobe_start();
        p0 = pulses;
        send_byte(8'h00);
        chk("R4 gcall strobe", pulses - p0, 1);
        chk("R4 gcall kind", match_kind, 2);
        chk("R4 gcall ack", sda_pull, 1);
        ack_clock();
        chk("R7 gcall release", sda_pull, 0);
        strobe_stop();
    endtask

    task automatic t_mismatch();
        int p0;
        own_cfg = 8'hA4;
        strobe_start();
        p0 = pulses;
        send_byte(8'h25);
        chk("R10 reversed addr strobe", pulses - p0, 0);
        chk("R5 mismatch kind", match_kind, 0);
        chk("R5 mismatch pull", sda_pull, 0);
        ack_clock();
        chk("R5 no pull on 9th", sda_pull, 0);
        strobe_stop();
    endtask

    task automatic t_ack_off();
        int p0;
        own_cfg = 8'hA4;
        ack_en = 1'b0;
        strobe_start();
        p0 = pulses;
        send_byte(8'hA4);
        chk("R6 ignored strobe", pulses - p0, 0);
        chk("R6 ignored kind", match_kind, 0);
        chk("R6 ignored pull", sda_pull, 0);
        ack_clock();
        ack_en = 1'b1;
        strobe_start();
        send_byte(8'hA4);
        chk("R6 resumed strobe", pulses - p0, 1);
        chk("R6 resumed kind", match_kind, 1);
        ack_clock();
        strobe_stop();
    endtask

    task automatic t_restart();
        int p0;
        own_cfg = 8'hA4;
        strobe_start();
        p0 = pulses;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        strobe_start();
        send_byte(8'hA5);
        chk("R8 restart strobe", pulses - p0, 1);
        chk("R8 restart rw", rw_bit, 1);
        chk("R8 restart kind", match_kind, 1);
        ack_clock();
        strobe_start();
        chk("R8 start clears kind", match_kind, 0);
        send_byte(8'hA4);
        chk("R8 second byte strobe", pulses - p0, 2);
        chk("R8 second byte rw", rw_bit, 0);
        ack_clock();
        strobe_stop();
    endtask

    task automatic t_stop_idle();
        int p0;
        own_cfg = 8'hA4;
        strobe_start();
        send_byte(8'hA4);
        fall();
        strobe_stop();
        chk("R9 stop releases pull", sda_pull, 0);
        p0 = pulses;
        send_byte(8'hA4);
        chk("R9 no match without start", pulses - p0, 0);
        chk("R9 idle pull", sda_pull, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_own_read();
        t_default_cfg();
        t_gcall();
        t_mismatch();
        t_ack_off();
        t_restart();
        t_stop_idle();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule